// File: doc/BRIEF.md
# IR Carrier Generator and Transmit Output

This block produces the modulated carrier for an infrared transmitter and drives the single transmit pin. The carrier's high and low phases have independent lengths, each set by an 8-bit count. Each count is loaded as two 4-bit nibbles through one shared write port. A high phase lasts count+1 clocks of the fast carrier clock, and a low phase lasts its own count+1 clocks.

The pin level comes from three sources: the port's output data latch, a per-symbol carrier-enable bit, and the running carrier. The carrier-enable bit is the most significant bit of the 9-bit table word being sent. When the latch is clear, the pin is low. When the latch is set and the enable bit is clear, the pin is steadily high. When both are set, the pin follows the carrier.

Each time carrier mode is entered, the carrier starts with a fresh high phase. A count written while the carrier runs waits for the next phase boundary, so the phase in progress is never cut short. The oscillator, the table memory and the processor core that feed these inputs lie outside the block.

Top module: `ir_carrier_tx`

## Requirements
- R1: After reset both counts are zero and `txOut` is low. With zero counts in carrier mode, the pin alternates one clock high and one clock low.
- R2: A write with `wrEn` high loads `wrData` into one nibble. `wrSel[1]` = 1 picks the high-phase count and 0 picks the low-phase count. `wrSel[0]` = 1 picks bits 7:4 and 0 picks bits 3:0.
- R3: In carrier mode, each high phase lasts H+1 clocks, where H is the high-phase count.
- R4: In carrier mode, each low phase lasts L+1 clocks, where L is the low-phase count.
- R5: While `outLatch` is 0, `txOut` is low, whatever `carrierFlag` is.
- R6: While `outLatch` is 1 and `carrierFlag` is 0, `txOut` is steadily high.
- R7: When `outLatch` and `carrierFlag` become 1 together, the carrier restarts with a full high phase. This holds even if a previous carrier was left part-way through a low phase.
- R8: A count written during a phase does not change that phase. The count is taken up when the next phase of its kind begins.
- R9: `txOut` is registered. A change on `outLatch` or `carrierFlag` shows on `txOut` one clock after the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock (oscillator rate) |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Nibble write strobe |
| wrSel | input | 2 | Nibble select: bit 1 picks the count (1 = high phase), bit 0 picks the nibble (1 = upper) |
| wrData | input | 4 | Nibble write data |
| outLatch | input | 1 | Port output data latch for the transmit pin |
| carrierFlag | input | 1 | Carrier enable, the top bit of the table word being sent |
| txOut | output | 1 | Transmit pin level |

## Verification
The pin level for a given set of inputs is due exactly one clock after the edge that samples them. The bench therefore changes inputs just after a falling edge, lets its behavioural model advance on the rising edge, and compares pin and model on the following falling edge, every cycle.

Phase lengths are measured as run lengths of equal pin samples taken on falling edges. These runs are compared against count+1 for each phase kind.

Count writes take effect at the first boundary edge after the write edge. The boundary test therefore places all four nibble writes inside a running low phase and expects the old length for that phase, then the new lengths afterwards.

// File: rtl/ir_carrier_pkg.sv
package ir_carrier_pkg;

  // Strobes from the phase control to the counting datapath.
  typedef struct packed {
    logic restart;     // carrier idle: rearm a fresh high phase
    logic flip;        // phase boundary: switch phase and reload length
    logic step;        // advance the phase counter
    logic leavingHigh; // the phase now ending is a high phase
    logic driveHigh;   // pin level to launch on this edge
  } carCtl_t;

endpackage

// File: rtl/ir_carrier_ctrl.sv
module ir_carrier_ctrl
  import ir_carrier_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    outLatch,
  input  logic    carrierFlag,
  input  logic    phaseDone,
  output carCtl_t ctl
);

  logic phaseHigh;
  logic carrierMode;

  assign carrierMode = outLatch & carrierFlag;

  always_comb begin
    ctl.restart     = ~carrierMode;
    ctl.flip        = carrierMode & phaseDone;
    ctl.step        = carrierMode & ~phaseDone;
    ctl.leavingHigh = phaseHigh;
    ctl.driveHigh   = outLatch & (~carrierFlag | phaseHigh);
  end

  // Phase register: held at high while idle so entry always begins high.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseHigh <= 1'b1;
    end else if (ctl.restart) begin
      phaseHigh <= 1'b1;
    end else if (ctl.flip) begin
      phaseHigh <= ~phaseHigh;
    end
  end

endmodule

// File: rtl/ir_carrier_dp.sv
module ir_carrier_dp
  import ir_carrier_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int NIB_W = 4,
  localparam int NIBS  = CNT_W / NIB_W,
  localparam int IDX_W = $clog2(NIBS),
  localparam int SEL_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  logic [NIB_W-1:0] wrData,
  input  carCtl_t          ctl,
  output logic             phaseDone,
  output logic             txOut
);

  logic [NIBS-1:0][NIB_W-1:0] hiNib;
  logic [NIBS-1:0][NIB_W-1:0] loNib;
  logic [CNT_W-1:0]           hiCount;
  logic [CNT_W-1:0]           loCount;
  logic [CNT_W-1:0]           phaseCnt;
  logic [CNT_W-1:0]           phaseLen;
  logic                       pickHigh;
  logic [IDX_W-1:0]           nibIdx;

  assign pickHigh = wrSel[SEL_W-1];
  assign nibIdx   = wrSel[IDX_W-1:0];
  assign hiCount  = hiNib;
  assign loCount  = loNib;

  // Staging count registers, written one nibble at a time.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiNib <= '0;
      loNib <= '0;
    end else if (wrEn) begin
      for (int n = 0; n < NIBS; n++) begin
        if (nibIdx == IDX_W'(n)) begin
          if (pickHigh) hiNib[n] <= wrData;
          else          loNib[n] <= wrData;
        end
      end
    end
  end

  assign phaseDone = (phaseCnt == phaseLen);

  // Phase counter; the length is captured only at a boundary or while idle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      phaseLen <= '0;
    end else if (ctl.restart) begin
      phaseCnt <= '0;
      phaseLen <= hiCount;
    end else if (ctl.flip) begin
      phaseCnt <= '0;
      phaseLen <= ctl.leavingHigh ? loCount : hiCount;
    end else if (ctl.step) begin
      phaseCnt <= phaseCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txOut <= 1'b0;
    else       txOut <= ctl.driveHigh;
  end

endmodule

// File: rtl/ir_carrier_tx.sv
module ir_carrier_tx
  import ir_carrier_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int NIB_W = 4,
  localparam int NIBS  = CNT_W / NIB_W,
  localparam int SEL_W = $clog2(NIBS) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [SEL_W-1:0] wrSel,
  input  logic [NIB_W-1:0] wrData,
  input  logic             outLatch,
  input  logic             carrierFlag,
  output logic             txOut
);

  carCtl_t ctl;
  logic    phaseDone;

  ir_carrier_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .outLatch    (outLatch),
    .carrierFlag (carrierFlag),
    .phaseDone   (phaseDone),
    .ctl         (ctl)
  );

  ir_carrier_dp #(.CNT_W(CNT_W), .NIB_W(NIB_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .wrData    (wrData),
    .ctl       (ctl),
    .phaseDone (phaseDone),
    .txOut     (txOut)
  );

endmodule

// File: rtl/ir_carrier_chk.sv
module ir_carrier_chk #(
  parameter int CNT_W = 8
) (
  input logic clk,
  input logic rstN,
  input logic outLatch,
  input logic carrierFlag,
  input logic txOut
);

  localparam int MAXRUN = 1 << CNT_W;

  logic             modeQ;
  logic             txQ;
  logic [CNT_W+1:0] runCnt;

  // Track how long the pin has held one level while carrier mode is active.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= 1'b0;
      txQ    <= 1'b0;
      runCnt <= '0;
    end else begin
      modeQ <= outLatch & carrierFlag;
      txQ   <= txOut;
      if (!modeQ)           runCnt <= '0;
      else if (txOut != txQ) runCnt <= (CNT_W+2)'(1);
      else                  runCnt <= runCnt + (CNT_W+2)'(1);
    end
  end

  always @(negedge clk) begin
    if (!rstN) begin
      assert_reset_low_R1: assert (!txOut);
    end
  end

  assert_latch_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    !outLatch |=> !txOut);

  assert_steady_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outLatch && !carrierFlag) |=> txOut);

  assert_fresh_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outLatch && carrierFlag && !modeQ) |=> txOut);

  // R3 / R4: no carrier phase can exceed the largest count plus one.
  assert_phase_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= (CNT_W+2)'(MAXRUN));

endmodule

bind ir_carrier_tx ir_carrier_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .outLatch    (outLatch),
  .carrierFlag (carrierFlag),
  .txOut       (txOut)
);

// File: tb/tb_ir_carrier_tx.sv
`timescale 1ns/100ps
module tb_ir_carrier_tx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrSel = '0;
  logic [3:0] wrData = '0;
  logic       outLatch = 1'b0;
  logic       carrierFlag = 1'b0;
  logic       txOut;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #2.5 clk = ~clk;

  ir_carrier_tx dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .outLatch(outLatch), .carrierFlag(carrierFlag), .txOut(txOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase kind, cycles spent, length of current phase.
  int mHi, mLo, mElapsed, mLen;
  bit mHigh, mTx;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mHi = 0; mLo = 0; mElapsed = 0; mLen = 0; mHigh = 1; mTx = 0;
    end else begin
      mTx = outLatch && (!carrierFlag || mHigh);
      if (!(outLatch && carrierFlag)) begin
        mHigh = 1; mElapsed = 0; mLen = mHi;
      end else if (mElapsed == mLen) begin
        mHigh = !mHigh; mElapsed = 0;
        mLen = mHigh ? mHi : mLo;
      end else begin
        mElapsed++;
      end
      if (wrEn) begin
        if (wrSel[1]) mHi = wrSel[0] ? ((mHi & 15) | (wrData << 4)) : ((mHi & 240) | wrData);
        else          mLo = wrSel[0] ? ((mLo & 15) | (wrData << 4)) : ((mLo & 240) | wrData);
      end
    end
  end

  // Per-cycle comparison and run-length monitor on falling edges.
  int runs[$];
  bit lastTx = 1'b0;
  int curRun = 0;

  always @(negedge clk) begin
    if (rstN) check(txOut === mTx, "R9 per-cycle model", int'(txOut), int'(mTx));
    if (txOut == lastTx) curRun++;
    else begin
      runs.push_back(curRun);
      lastTx = txOut;
      curRun = 1;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic clearRuns();
    runs.delete();
    lastTx = txOut;
    curRun = 1;
  endtask

  task automatic setMode(input bit l, input bit f);
    outLatch = l;
    carrierFlag = f;
  endtask

  task automatic wr(input bit [1:0] s, input bit [3:0] d);
    wrEn = 1'b1; wrSel = s; wrData = d;
    cyc(1);
    wrEn = 1'b0;
  endtask

  task automatic expectRuns(input int exp[$], input string tag);
    for (int i = 0; i < exp.size(); i++) begin
      int act;
      act = (i + 1 < runs.size()) ? runs[i+1] : -1;
      check(act == exp[i], tag, act, exp[i]);
    end
  endtask

  initial begin
    int cntBad;
    cyc(3);
    check(txOut === 1'b0, "R1 reset low", int'(txOut), 0);
    rstN = 1'b1;
    cyc(1);

    // R1: zero counts alternate one high, one low
    clearRuns(); setMode(1, 1); cyc(10);
    expectRuns('{1, 1, 1, 1}, "R1 zero-count carrier");

    // R5: latch low holds pin low even with carrier enabled
    setMode(0, 1);
    cntBad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); if (txOut !== 1'b0) cntBad++;
    end
    #1;
    check(cntBad == 0, "R5 latch low", cntBad, 0);

    // R3 / R4: high 5 -> 6 clocks, low 9 -> 10 clocks
    wr(2'b11, 4'h0); wr(2'b10, 4'h5); wr(2'b01, 4'h0); wr(2'b00, 4'h9);
    cyc(2);
    clearRuns(); setMode(1, 1); cyc(40);
    expectRuns('{6, 10, 6, 10}, "R3 R4 phase lengths");
    setMode(0, 0); cyc(3);

    // R2: nibble placement, high 0x12 -> 19, low 0x03 -> 4
    wr(2'b11, 4'h1); wr(2'b10, 4'h2); wr(2'b00, 4'h3); wr(2'b01, 4'h0);
    cyc(2);
    clearRuns(); setMode(1, 1); cyc(60);
    expectRuns('{19, 4, 19, 4}, "R2 nibble select");

    // R6: steady high without carrier
    setMode(1, 0);
    cntBad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); if (txOut !== 1'b1) cntBad++;
    end
    #1;
    check(cntBad == 0, "R6 steady high", cntBad, 0);

    // R8: writes inside a low phase leave it intact
    setMode(0, 0);
    wr(2'b11, 4'h0); wr(2'b10, 4'h5); wr(2'b01, 4'h0); wr(2'b00, 4'h9);
    cyc(2);
    clearRuns(); setMode(1, 1); cyc(8);
    wr(2'b11, 4'h0); wr(2'b10, 4'h2); wr(2'b01, 4'h0); wr(2'b00, 4'h3);
    cyc(30);
    expectRuns('{6, 10, 3, 4, 3}, "R8 boundary update");
    setMode(0, 0);

    // R7: leave carrier mid low phase, re-enter: fresh full high phase
    wr(2'b10, 4'h5); wr(2'b00, 4'h9);
    cyc(2);
    clearRuns(); setMode(1, 1); cyc(9);
    setMode(1, 0); cyc(1);
    setMode(1, 1); cyc(30);
    expectRuns('{6, 3, 7, 10, 6}, "R7 restart high");

    // R9: one-clock latency at the pin
    setMode(0, 0); cyc(3);
    setMode(1, 0);
    check(txOut === 1'b0, "R9 before edge", int'(txOut), 0);
    @(posedge clk); #1;
    check(txOut === 1'b1, "R9 after edge", int'(txOut), 1);
    @(negedge clk); #1;
    setMode(0, 0);
    check(txOut === 1'b1, "R9 hold before edge", int'(txOut), 1);
    @(posedge clk); #1;
    check(txOut === 1'b0, "R9 low after edge", int'(txOut), 0);
    cyc(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule